// File: doc/BRIEF.md
# Store-and-Forward Packet Feeder for a 256-bit MAC Transmit Port

This block sits in front of the transmit client port of a 40G Ethernet MAC. An upstream source hands it packets over a valid/ready stream with start, end and empty markers. That source may stall or leave idle cycles in the middle of a packet. The block writes every accepted beat into an internal beat buffer. It offers a packet to the MAC only after the last beat of that packet is stored, so the downstream stream carries each packet in back-to-back cycles with no holes.

Two filters sit on the way in. A frame of fewer than nine bytes is removed before it becomes visible to the read side. A frame too long for the buffer is cut short, thrown away as a whole, and reported with a one-cycle error pulse. On the way out, no new packet starts while the lane-stability input is low. Byte 0 of a packet travels in the top byte lane, bits [255:248]. The empty field counts the unused low-order byte lanes of the last beat.

Top module: `pkt_sf_feeder`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_valid` is 0, `src_ready` is 1 and `oversize_err` is 0.
- R2: No beat of a packet appears downstream before that packet's end beat has been accepted upstream. With an empty buffer, lanes stable and the downstream port idle, the start beat is offered in the cycle right after the end beat is accepted, even if the upstream source paused mid-packet.
- R3: Once a start beat has transferred downstream, `tx_valid` stays high in every cycle up to and including the end beat, and no start marker appears before that end beat.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sop`, `tx_eop`, `tx_empty` and `tx_valid` hold their values into the next cycle. A beat transfers in any cycle where `tx_valid` and `tx_ready` are both high, with zero ready latency.
- R5: A new packet is first offered only in a cycle where `lanes_stable` is 1. A stored packet stays back while `lanes_stable` is 0. A start beat that is already offered stays offered until accepted, even if `lanes_stable` falls.
- R6: A packet whose byte count (32 × beats − empty on the end beat) is below 9 never reaches the downstream port. A single beat with empty 24 (8 bytes) or 31 (1 byte) is dropped. A single beat with empty 23 (9 bytes) is forwarded.
- R7: Forwarded packets leave in arrival order. Every beat keeps its data, its start and end markers, and (on the end beat) its empty value.
- R8: The buffer holds 64 beats. When 64 beats are stored and none are read, `src_ready` is 0 until a beat leaves.
- R9: A packet longer than 64 beats is dropped entirely. `oversize_err` pulses high for exactly one cycle, and the rest of that packet is taken in and discarded. A packet of exactly 64 beats is forwarded with no error. A packet after a dropped one is forwarded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Upstream beat valid |
| src_ready | output | 1 | Upstream beat accepted when high together with valid |
| src_data | input | 256 | Upstream beat data, byte 0 in bits [255:248] |
| src_sop | input | 1 | Upstream first beat of a packet |
| src_eop | input | 1 | Upstream last beat of a packet |
| src_empty | input | 5 | Unused low byte lanes on the last beat |
| tx_valid | output | 1 | Downstream beat valid |
| tx_ready | input | 1 | Downstream ready, zero latency |
| tx_data | output | 256 | Downstream beat data |
| tx_sop | output | 1 | Downstream first beat of a packet |
| tx_eop | output | 1 | Downstream last beat of a packet |
| tx_empty | output | 5 | Downstream unused byte lanes on the last beat |
| lanes_stable | input | 1 | Link lanes stable; gates the start of each packet |
| oversize_err | output | 1 | One-cycle pulse when an over-long packet is dropped |

## Verification
A stored-packet count that is off by one shows up at once. Either a start beat appears before its end beat was accepted, or `tx_valid` never rises for a complete packet. The bench catches both within one cycle of the upstream end beat. A commit pointer or read pointer that slips shows up as wrong data or misplaced markers on the very next downstream beat, which the scoreboard compares in content and order. A rollback that fails after a runt or an over-long packet leaves stray beats in the buffer. They appear as an unexpected downstream packet, or as a short count of accepted upstream beats once the buffer should be full.

// File: rtl/pkt_sf_pkg.sv
package pkt_sf_pkg;

    // Write side: storing beats of the current packet, or swallowing the
    // tail of a packet that no longer fits.
    typedef enum logic {
        WM_STORE   = 1'b0,
        WM_DISCARD = 1'b1
    } wr_mode_e;

    // Read side: nothing offered, a start beat offered but not taken,
    // or inside a packet.
    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ARMED = 2'd1,
        RS_SEND  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/sf_beat_ram.sv
module sf_beat_ram #(
    parameter int W     = 263,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous read keeps the offered beat on the output with no
    // extra stage, so a stalled beat stays put while the address holds.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sf_wr_ctrl.sv
module sf_wr_ctrl
    import pkt_sf_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int BYTES     = 32,
    parameter int MIN_BYTES = 9,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = PTR_W + 1,
    localparam int EMPTY_W  = $clog2(BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic [CNT_W-1:0]   rd_ptr,
    output logic               in_ready,
    output logic               we,
    output logic [PTR_W-1:0]   waddr,
    output logic               commit,
    output logic               err_pulse
);

    localparam int TOT_W = CNT_W + EMPTY_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] wr;
        logic [CNT_W-1:0] cm;
        wr_mode_e         mode;
        logic             err;
    } wr_state_t;

    wr_state_t s_d, s_q;

    logic [CNT_W-1:0] pkt_beats;
    logic [CNT_W-1:0] occ;
    logic             full;
    logic             overflow;
    logic             acc;
    logic [TOT_W-1:0] tot_bytes;
    logic             runt;

    always_comb begin
        pkt_beats = s_q.wr - s_q.cm;
        occ       = s_q.wr - rd_ptr;
        full      = (occ == CNT_W'(DEPTH));
        // The open packet alone fills the buffer and has no end yet.
        overflow  = (s_q.mode == WM_STORE) && (pkt_beats == CNT_W'(DEPTH));
        in_ready  = (s_q.mode == WM_DISCARD) || !full;
        acc       = in_valid && in_ready;

        // Bytes of the packet if the current beat closes it.
        tot_bytes = (TOT_W'(pkt_beats) << EMPTY_W) + TOT_W'(BYTES)
                    - TOT_W'(in_empty);
        runt      = tot_bytes < TOT_W'(MIN_BYTES);

        s_d     = s_q;
        s_d.err = 1'b0;
        we      = 1'b0;
        commit  = 1'b0;

        if (overflow) begin
            s_d.wr   = s_q.cm;
            s_d.mode = WM_DISCARD;
            s_d.err  = 1'b1;
        end else if (acc) begin
            if (s_q.mode == WM_DISCARD) begin
                if (in_eop) begin
                    s_d.mode = WM_STORE;
                end
            end else begin
                we = 1'b1;
                if (in_eop) begin
                    if (runt) begin
                        s_d.wr = s_q.cm;
                    end else begin
                        s_d.wr = s_q.wr + 1'b1;
                        s_d.cm = s_q.wr + 1'b1;
                        commit = 1'b1;
                    end
                end else begin
                    s_d.wr = s_q.wr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wr: '0, cm: '0, mode: WM_STORE, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign waddr     = s_q.wr[PTR_W-1:0];
    assign err_pulse = s_q.err;

endmodule

// File: rtl/sf_rd_ctrl.sv
module sf_rd_ctrl
    import pkt_sf_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             lanes_ok,
    input  logic             out_ready,
    input  logic             beat_eop,
    output logic             out_valid,
    output logic [CNT_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] raddr
);

    typedef struct packed {
        rd_state_e        st;
        logic [CNT_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } rd_state_t;

    rd_state_t s_d, s_q;
    logic      xfer;

    always_comb begin
        unique case (s_q.st)
            RS_IDLE:  out_valid = (s_q.cnt != '0) && lanes_ok;
            default:  out_valid = 1'b1;
        endcase
        xfer = out_valid && out_ready;

        s_d = s_q;
        if (xfer) begin
            s_d.rd = s_q.rd + 1'b1;
            s_d.st = beat_eop ? RS_IDLE : RS_SEND;
        end else if (s_q.st == RS_IDLE && out_valid) begin
            s_d.st = RS_ARMED;
        end
        s_d.cnt = s_q.cnt + CNT_W'(commit) - CNT_W'(xfer && beat_eop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: RS_IDLE, rd: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_ptr = s_q.rd;
    assign raddr  = s_q.rd[PTR_W-1:0];

endmodule

// File: rtl/pkt_sf_feeder.sv
module pkt_sf_feeder #(
    parameter int DATA_W    = 256,
    parameter int DEPTH     = 64,
    parameter int MIN_BYTES = 9,
    localparam int BYTES    = DATA_W / 8,
    localparam int EMPTY_W  = $clog2(BYTES),
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = PTR_W + 1,
    localparam int BEAT_W   = DATA_W + EMPTY_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_valid,
    output logic               src_ready,
    input  logic [DATA_W-1:0]  src_data,
    input  logic               src_sop,
    input  logic               src_eop,
    input  logic [EMPTY_W-1:0] src_empty,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [DATA_W-1:0]  tx_data,
    output logic               tx_sop,
    output logic               tx_eop,
    output logic [EMPTY_W-1:0] tx_empty,
    input  logic               lanes_stable,
    output logic               oversize_err
);

    logic              we;
    logic [PTR_W-1:0]  waddr;
    logic [PTR_W-1:0]  raddr;
    logic [CNT_W-1:0]  rd_ptr;
    logic              commit;
    logic [BEAT_W-1:0] wbeat;
    logic [BEAT_W-1:0] rbeat;

    assign wbeat = {src_sop, src_eop, src_empty, src_data};

    sf_wr_ctrl #(
        .DEPTH     (DEPTH),
        .BYTES     (BYTES),
        .MIN_BYTES (MIN_BYTES)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (src_valid),
        .in_eop    (src_eop),
        .in_empty  (src_empty),
        .rd_ptr    (rd_ptr),
        .in_ready  (src_ready),
        .we        (we),
        .waddr     (waddr),
        .commit    (commit),
        .err_pulse (oversize_err)
    );

    sf_beat_ram #(
        .W     (BEAT_W),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wbeat),
        .raddr (raddr),
        .rdata (rbeat)
    );

    sf_rd_ctrl #(
        .DEPTH (DEPTH)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .lanes_ok  (lanes_stable),
        .out_ready (tx_ready),
        .beat_eop  (tx_eop),
        .out_valid (tx_valid),
        .rd_ptr    (rd_ptr),
        .raddr     (raddr)
    );

    assign {tx_sop, tx_eop, tx_empty, tx_data} = rbeat;

endmodule

// File: rtl/pkt_sf_feeder_chk.sv
module pkt_sf_feeder_chk #(
    parameter int DATA_W    = 256,
    parameter int MIN_BYTES = 9,
    localparam int BYTES    = DATA_W / 8,
    localparam int EMPTY_W  = $clog2(BYTES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [DATA_W-1:0]  tx_data,
    input logic               tx_sop,
    input logic               tx_eop,
    input logic [EMPTY_W-1:0] tx_empty,
    input logic               lanes_stable,
    input logic               oversize_err
);

    // R4: a stalled beat holds every field
    p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop)
                                  && $stable(tx_eop) && $stable(tx_empty));

    // R3: after a non-final transfer the next beat follows at once, mid-packet
    p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !tx_eop |=> tx_valid && !tx_sop);

    // R5: a start beat not carried over from a stall needs stable lanes
    p_lanes_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_sop && !$past(tx_valid && !tx_ready) |-> lanes_stable);

    // R6: a single-beat packet that leaves has at least the minimum bytes
    p_no_runt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_sop && tx_eop |->
            ((EMPTY_W+1)'(BYTES) - (EMPTY_W+1)'(tx_empty)) >= (EMPTY_W+1)'(MIN_BYTES));

    // R9: the error output is a single-cycle pulse
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oversize_err |=> !oversize_err);

endmodule

bind pkt_sf_feeder pkt_sf_feeder_chk #(
    .DATA_W    (DATA_W),
    .MIN_BYTES (MIN_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_sop       (tx_sop),
    .tx_eop       (tx_eop),
    .tx_empty     (tx_empty),
    .lanes_stable (lanes_stable),
    .oversize_err (oversize_err)
);

// File: tb/pkt_sf_feeder_test.sv
module pkt_sf_feeder_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 256;
    localparam int EW         = 5;

    typedef struct packed {
        logic          sop;
        logic          eop;
        logic [EW-1:0] empty;
        logic [DATA_W-1:0] data;
    } beat_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              src_valid = 1'b0;
    logic              src_ready;
    logic [DATA_W-1:0] src_data = '0;
    logic              src_sop = 1'b0;
    logic              src_eop = 1'b0;
    logic [EW-1:0]     src_empty = '0;
    logic              tx_valid;
    logic              tx_ready = 1'b0;
    logic [DATA_W-1:0] tx_data;
    logic              tx_sop;
    logic              tx_eop;
    logic [EW-1:0]     tx_empty;
    logic              lanes_stable = 1'b0;
    logic              oversize_err;

    int checks = 0;
    int errors = 0;
    int accepted = 0;
    int err_cnt = 0;
    int out_pkts = 0;
    int ready_mode = 1;      // 0 low, 1 high, 2 pseudo-random
    beat_t exp_q[$];

    pkt_sf_feeder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_valid    (src_valid),
        .src_ready    (src_ready),
        .src_data     (src_data),
        .src_sop      (src_sop),
        .src_eop      (src_eop),
        .src_empty    (src_empty),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .tx_sop       (tx_sop),
        .tx_eop       (tx_eop),
        .tx_empty     (tx_empty),
        .lanes_stable (lanes_stable),
        .oversize_err (oversize_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    function automatic logic [DATA_W-1:0] mk_data(input int id, input int b);
        return {4{id ^ 32'h5A00_0000, b}};
    endfunction

    // Downstream ready pattern
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (ready_mode)
                0:       tx_ready = 1'b0;
                1:       tx_ready = 1'b1;
                default: tx_ready = lfsr[0] | lfsr[3];
            endcase
        end
    end

    // Driver: one packet, pushes expected beats when kept
    task automatic send_pkt(input int id, input int nbeats, input int last_empty,
                            input bit keep, input int gap);
        for (int b = 0; b < nbeats; b++) begin
            beat_t e;
            src_data  = mk_data(id, b);
            src_sop   = (b == 0);
            src_eop   = (b == nbeats - 1);
            src_empty = (b == nbeats - 1) ? EW'(last_empty) : '0;
            src_valid = 1'b1;
            @(negedge clk);
            while (!src_ready) @(negedge clk);
            @(posedge clk);
            accepted++;
            if (keep) begin
                e.sop = src_sop; e.eop = src_eop; e.empty = src_empty; e.data = src_data;
                exp_q.push_back(e);
            end
            #1;
            src_valid = 1'b0;
            if (b != nbeats - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(posedge clk);
                    #1;
                end
            end
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (6) @(posedge clk);
        #1;
    endtask

    // Monitor / scoreboard
    initial begin
        bit    in_pkt = 0;
        bit    prev_stall = 0;
        beat_t prev;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (oversize_err) err_cnt++;
                if (prev_stall) begin
                    check(tx_valid && tx_sop == prev.sop && tx_eop == prev.eop &&
                          tx_data == prev.data && (!tx_eop || tx_empty == prev.empty),
                          "R4 stalled beat held",
                          $sformatf("v%0b s%0b e%0b", tx_valid, tx_sop, tx_eop),
                          $sformatf("v1 s%0b e%0b", prev.sop, prev.eop));
                end
                if (in_pkt) begin
                    check(tx_valid, "R3 no idle inside packet", $sformatf("%0b", tx_valid), "1");
                end
                if (tx_valid && tx_sop && !prev_stall && !in_pkt) begin
                    check(lanes_stable, "R5 start only with lanes stable",
                          $sformatf("%0b", lanes_stable), "1");
                end
                if (tx_valid && tx_ready) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R7 unexpected downstream beat",
                              $sformatf("%h", tx_data[63:0]), "none");
                    end else begin
                        beat_t e;
                        e = exp_q.pop_front();
                        check(tx_data == e.data && tx_sop == e.sop && tx_eop == e.eop &&
                              (!e.eop || tx_empty == e.empty),
                              "R7 beat content and order",
                              $sformatf("s%0b e%0b m%0d %h", tx_sop, tx_eop, tx_empty, tx_data[63:0]),
                              $sformatf("s%0b e%0b m%0d %h", e.sop, e.eop, e.empty, e.data[63:0]));
                    end
                    if (tx_sop) out_pkts++;
                    in_pkt = !tx_eop;
                end
                prev_stall = tx_valid && !tx_ready;
                prev.sop = tx_sop; prev.eop = tx_eop; prev.empty = tx_empty; prev.data = tx_data;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        int e0;
        int p0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!tx_valid && src_ready && !oversize_err, "R1 reset outputs",
              $sformatf("v%0b r%0b e%0b", tx_valid, src_ready, oversize_err), "v0 r1 e0");
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid && src_ready && !oversize_err, "R1 after reset",
              $sformatf("v%0b r%0b e%0b", tx_valid, src_ready, oversize_err), "v0 r1 e0");

        // R5: stored packet held while lanes unstable
        ready_mode = 1;
        @(posedge clk); #1;
        send_pkt(1, 2, 4, 1, 0);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(!tx_valid, "R5 held while lanes unstable", $sformatf("%0b", tx_valid), "0");
        @(posedge clk); #1; lanes_stable = 1'b1;
        @(negedge clk);
        check(tx_valid && tx_sop, "R5 released when lanes stable",
              $sformatf("v%0b s%0b", tx_valid, tx_sop), "v1 s1");
        drain();

        // R5: offered start stays offered if lanes fall
        ready_mode = 0;
        send_pkt(2, 1, 0, 1, 0);
        repeat (3) @(posedge clk);
        #1; lanes_stable = 1'b0;
        @(negedge clk);
        check(tx_valid && tx_sop, "R5 armed start kept", $sformatf("v%0b", tx_valid), "1");
        @(posedge clk); #1; ready_mode = 1;
        drain();
        lanes_stable = 1'b1;

        // R2: store and forward with upstream pauses
        send_pkt(3, 2, 0, 1, 3);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!tx_valid, "R2 nothing before end beat", $sformatf("%0b", tx_valid), "0");
        @(posedge clk); #1;
        send_pkt(3, 0, 0, 1, 0);
        begin
            beat_t e;
            src_data = mk_data(4, 0); src_sop = 1; src_eop = 0; src_empty = 0; src_valid = 1;
            @(negedge clk); while (!src_ready) @(negedge clk);
            @(posedge clk); accepted++;
            e.sop = 1; e.eop = 0; e.empty = 0; e.data = src_data; exp_q.push_back(e);
            #1; src_valid = 0;
            repeat (4) begin @(posedge clk); #1; end
            @(negedge clk);
            check(!tx_valid, "R2 paused packet not offered", $sformatf("%0b", tx_valid), "0");
            @(posedge clk); #1;
            src_data = mk_data(4, 1); src_sop = 0; src_eop = 1; src_empty = 5; src_valid = 1;
            @(negedge clk); while (!src_ready) @(negedge clk);
            @(posedge clk); accepted++;
            e.sop = 0; e.eop = 1; e.empty = 5; e.data = src_data; exp_q.push_back(e);
            #1; src_valid = 0;
            @(negedge clk);
            check(tx_valid && tx_sop, "R2 start one cycle after end accepted",
                  $sformatf("v%0b s%0b", tx_valid, tx_sop), "v1 s1");
        end
        drain();

        // R6: runt filtering
        p0 = out_pkts;
        ready_mode = 2;
        send_pkt(10, 1, 24, 0, 0);
        send_pkt(11, 1, 23, 1, 0);
        send_pkt(12, 1, 31, 0, 0);
        send_pkt(13, 2, 31, 1, 1);
        drain();
        check(out_pkts - p0 == 2, "R6 runts dropped, 9 bytes kept",
              $sformatf("%0d", out_pkts - p0), "2");

        // R8: full buffer backpressure
        ready_mode = 0;
        base = accepted;
        send_pkt(20, 40, 0, 1, 0);
        fork
            send_pkt(21, 30, 7, 1, 0);
        join_none
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(accepted - base == 64 && !src_ready, "R8 stall at 64 beats",
              $sformatf("%0d r%0b", accepted - base, src_ready), "64 r0");
        @(posedge clk); #1; ready_mode = 1;
        wait fork;
        drain();

        // R9: oversize drop, exact-fit, recovery
        e0 = err_cnt;
        send_pkt(30, 70, 0, 0, 0);
        drain();
        check(err_cnt - e0 == 1, "R9 one error pulse for oversize",
              $sformatf("%0d", err_cnt - e0), "1");
        p0 = out_pkts;
        send_pkt(31, 64, 2, 1, 0);
        drain();
        check(err_cnt - e0 == 1 && out_pkts - p0 == 1, "R9 64-beat packet fits",
              $sformatf("err%0d pk%0d", err_cnt - e0, out_pkts - p0), "err1 pk1");
        send_pkt(32, 3, 9, 1, 2);
        drain();

        // R7: mixed traffic with random downstream stalls
        ready_mode = 2;
        for (int i = 0; i < 20; i++) begin
            int len = (i * 5) % 9 + 1;
            int emp = (i * 7) % 32;
            send_pkt(100 + i, len, emp, (len * 32 - emp) >= 9, i % 3);
        end
        drain();
        check(exp_q.size() == 0, "R7 all expected beats delivered",
              $sformatf("%0d", exp_q.size()), "0");

        summary();
        $finish;
    end

endmodule